// File: doc/BRIEF.md
# Indexed effective address generator

This block forms the 16-bit effective address of a memory operand for an 8-bit CPU with a 64 KB address space. A decoder presents one request per instruction: an addressing mode code, a pointer-register select, an indirection flag and the offset field taken from the instruction stream. The block also receives the current X, Y, U, S and PC values and the A and B accumulators, which together form the 16-bit D. It returns the address one cycle later. For modes that step a pointer register, it also returns the new register value with a write-back strobe.

The block holds the direct page byte itself. This byte is loaded through a write port and supplies the upper half of direct-mode addresses. For indirect requests the first result is the location of a stored pointer and is flagged as such. The block then stays busy until the caller returns the fetched 16-bit word. One cycle later that word comes out as the final effective address. Combinations that are not allowed are reported as illegal, and such a request has no side effect.

Top module: `ea_unit`

## Requirements
- R1: After synchronous reset, `res_valid` and `busy` are 0 and the direct page byte is 00h.
- R2: Mode 0 (direct) yields {page byte, offset[7:0]}. Mode 1 (extended) yields offset[15:0]. A page write through `page_we` applies to requests made in later cycles.
- R3: Modes 2, 3, 4 and 5 add to the selected pointer (select 0=X, 1=Y, 2=U, 3=S) an offset of zero, offset[4:0] sign-extended, offset[7:0] sign-extended, or offset[15:0], respectively.
- R4: Modes 6 and 7 add A or B, sign-extended, to the selected pointer. Mode 8 adds D = {A,B} as an unsigned 16-bit value.
- R5: Modes 9 and 10 (post-increment by 1 or 2) output the pointer's current value as the address. They also raise `wb_en`, with `wb_sel` equal to the select and `wb_value` equal to pointer+1 or pointer+2.
- R6: Modes 11 and 12 (pre-decrement by 1 or 2) output pointer−1 or pointer−2 as both the address and `wb_value`, and raise `wb_en`.
- R7: Modes 13 and 14 add offset[7:0] sign-extended, or offset[15:0], to PC.
- R8: All address and write-back arithmetic wraps modulo 65536.
- R9: An indirect request is legal only with modes 1, 4, 5, 10, 12, 13 and 14. Mode 15 is reserved. An illegal request gives a result with `res_illegal`=1, `res_ind`=0 and `wb_en`=0, and does not make the block busy.
- R10: A legal indirect request first yields `res_ind`=1, with the pointer location as the address, and then holds `busy`. The cycle after `ptr_valid`, the block yields `res_ind`=0 with `res_addr` equal to `ptr_data`, and `busy` falls.
- R11: For an indirect step mode, `wb_en` accompanies only the first result and never the final one.
- R12: A request presented while `busy` is 1 is dropped and produces no result.
- R13: An accepted request produces its result exactly one clock cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 4 | Addressing mode code |
| req_ind | input | 1 | Indirection requested |
| req_sel | input | 2 | Pointer select: 0=X, 1=Y, 2=U, 3=S |
| req_off | input | 16 | Offset or operand field |
| reg_x | input | 16 | X register |
| reg_y | input | 16 | Y register |
| reg_u | input | 16 | U register |
| reg_s | input | 16 | S register |
| reg_pc | input | 16 | Program counter |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| page_we | input | 1 | Direct page byte write strobe |
| page_wdata | input | 8 | New direct page byte |
| ptr_valid | input | 1 | Fetched pointer word is present |
| ptr_data | input | 16 | Fetched pointer word |
| busy | output | 1 | Waiting for a pointer word |
| res_valid | output | 1 | Result strobe |
| res_addr | output | 16 | Effective address, or pointer location when res_ind |
| res_ind | output | 1 | Address is a pointer location to fetch |
| res_illegal | output | 1 | Request combination is not allowed |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_sel | output | 2 | Pointer to write back |
| wb_value | output | 16 | New pointer value |

## Verification
A stuck wait state would show as `busy` staying high and every later request being lost. The first request after the pointer word arrives would then have no result in the following cycle. A wrong direct page byte or a wrong sign extension shows up in `res_addr` in the cycle after the request. A duplicated write-back shows as `wb_en` on the final result of an indirect step request. That result comes one cycle after `ptr_valid`, so each of these faults appears within two cycles of the stimulus that exposes it.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2 * DATA_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [3:0] {
        M_DIRECT   = 4'd0,
        M_EXTENDED = 4'd1,
        M_ZERO     = 4'd2,
        M_OFF5     = 4'd3,
        M_OFF8     = 4'd4,
        M_OFF16    = 4'd5,
        M_ACC_A    = 4'd6,
        M_ACC_B    = 4'd7,
        M_ACC_D    = 4'd8,
        M_INC1     = 4'd9,
        M_INC2     = 4'd10,
        M_DEC1     = 4'd11,
        M_DEC2     = 4'd12,
        M_PCR8     = 4'd13,
        M_PCR16    = 4'd14,
        M_RSVD     = 4'd15
    } ea_mode_e;

    typedef enum logic [1:0] {
        P_X = 2'd0,
        P_Y = 2'd1,
        P_U = 2'd2,
        P_S = 2'd3
    } ptr_sel_e;

    typedef struct packed {
        addr_t    addr;
        logic     ind;
        logic     illegal;
        logic     wb_en;
        ptr_sel_e wb_sel;
        addr_t    wb_value;
    } ea_result_t;

    // Indirection is only meaningful with wide offsets and by-2 steps.
    function automatic logic ind_legal(ea_mode_e m);
        case (m)
            M_EXTENDED, M_OFF8, M_OFF16, M_INC2, M_DEC2, M_PCR8, M_PCR16: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic is_step(ea_mode_e m);
        return (m == M_INC1) || (m == M_INC2) || (m == M_DEC1) || (m == M_DEC2);
    endfunction

endpackage

// File: rtl/ea_base_select.sv
module ea_base_select
    import ea_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NPTR = 4
) (
    input  ptr_sel_e        sel,
    input  logic [AW-1:0]   ptr_x,
    input  logic [AW-1:0]   ptr_y,
    input  logic [AW-1:0]   ptr_u,
    input  logic [AW-1:0]   ptr_s,
    output logic [AW-1:0]   base
);
    localparam int SW = $clog2(NPTR);

    logic [AW-1:0] bank [NPTR];
    logic [AW-1:0] pick [NPTR];

    assign bank[0] = ptr_x;
    assign bank[1] = ptr_y;
    assign bank[2] = ptr_u;
    assign bank[3] = ptr_s;

    // AND-OR selection tree, one leg per pointer register.
    for (genvar i = 0; i < NPTR; i++) begin : g_leg
        assign pick[i] = (sel == ptr_sel_e'(SW'(i))) ? bank[i] : '0;
    end

    always_comb begin
        base = '0;
        for (int i = 0; i < NPTR; i++) base = base | pick[i];
    end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
    import ea_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  ea_mode_e       mode,
    input  logic           ind,
    input  ptr_sel_e       sel,
    input  logic [AW-1:0]  base,
    input  logic [AW-1:0]  pc,
    input  logic [AW-1:0]  off,
    input  logic [DW-1:0]  acc_a,
    input  logic [DW-1:0]  acc_b,
    input  logic [DW-1:0]  page,
    output ea_result_t     res
);
    localparam int SHORT_W = 5;

    logic [AW-1:0] off_short, off_byte, a_ext, b_ext, d_val;
    logic [AW-1:0] opa, opb, sum;
    logic [AW-1:0] step, stepped;
    logic          bad_mode;

    assign off_short = {{(AW-SHORT_W){off[SHORT_W-1]}}, off[SHORT_W-1:0]};
    assign off_byte  = {{(AW-DW){off[DW-1]}}, off[DW-1:0]};
    assign a_ext     = {{(AW-DW){acc_a[DW-1]}}, acc_a};
    assign b_ext     = {{(AW-DW){acc_b[DW-1]}}, acc_b};
    assign d_val     = {acc_a, acc_b};

    // Single adder shared by offset, accumulator and PC-relative forms.
    always_comb begin
        opa = base;
        opb = '0;
        case (mode)
            M_OFF5:  opb = off_short;
            M_OFF8:  opb = off_byte;
            M_OFF16: opb = off;
            M_ACC_A: opb = a_ext;
            M_ACC_B: opb = b_ext;
            M_ACC_D: opb = d_val;
            M_PCR8:  begin opa = pc; opb = off_byte; end
            M_PCR16: begin opa = pc; opb = off;      end
            default: ;
        endcase
    end

    assign sum = opa + opb;

    // Separate step adder for the pointer write-back.
    always_comb begin
        case (mode)
            M_INC1:  step = AW'(1);
            M_INC2:  step = AW'(2);
            M_DEC1:  step = {AW{1'b1}};
            M_DEC2:  step = {{(AW-1){1'b1}}, 1'b0};
            default: step = '0;
        endcase
    end

    assign stepped  = base + step;
    assign bad_mode = (mode == M_RSVD) || (ind && !ind_legal(mode));

    always_comb begin
        res          = '0;
        res.wb_sel   = sel;
        res.wb_value = stepped;
        case (mode)
            M_DIRECT:       res.addr = {page, off[DW-1:0]};
            M_EXTENDED:     res.addr = off;
            M_INC1, M_INC2: res.addr = base;
            M_DEC1, M_DEC2: res.addr = stepped;
            M_RSVD:         res.addr = '0;
            default:        res.addr = sum;
        endcase
        if (bad_mode) begin
            res.illegal = 1'b1;
        end else begin
            res.ind   = ind;
            res.wb_en = is_step(mode);
        end
    end
endmodule

// File: rtl/ea_page_reg.sv
module ea_page_reg
    import ea_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] page
);
    always_ff @(posedge clk) begin
        if (rst)     page <= '0;
        else if (we) page <= wdata;
    end

    a_r1_page_cleared: assert property (@(posedge clk) rst |=> page == '0);
endmodule

// File: rtl/ea_seq.sv
module ea_seq
    import ea_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  ea_result_t    calc,
    input  logic          ptr_valid,
    input  logic [AW-1:0] ptr_data,
    output logic          busy,
    output logic          out_valid,
    output ea_result_t    out
);
    typedef enum logic {S_IDLE, S_WAIT} state_e;

    state_e st;
    logic   take_req, take_ptr;

    assign take_req = req_valid && (st == S_IDLE);
    assign take_ptr = ptr_valid && (st == S_WAIT);
    assign busy     = (st == S_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            out_valid <= 1'b0;
            out       <= '0;
        end else begin
            out_valid <= 1'b0;
            out.wb_en <= 1'b0;
            if (take_req) begin
                out_valid <= 1'b1;
                out       <= calc;
                if (calc.ind) st <= S_WAIT;
            end else if (take_ptr) begin
                out_valid   <= 1'b1;
                out.addr    <= ptr_data;
                out.ind     <= 1'b0;
                out.illegal <= 1'b0;
                st          <= S_IDLE;
            end
        end
    end

    // R10: the fetched word becomes the final address one cycle later.
    a_r10_ptr_final: assert property (@(posedge clk) disable iff (rst)
        take_ptr |=> out_valid && !out.ind && out.addr == $past(ptr_data) && !busy);

    // R11: the final result of an indirect request never writes back.
    a_r11_single_wb: assert property (@(posedge clk) disable iff (rst)
        take_ptr |=> !out.wb_en);

    // R12: while waiting without a pointer word, nothing is produced.
    a_r12_busy_quiet: assert property (@(posedge clk) disable iff (rst)
        (busy && !ptr_valid) |=> !out_valid && busy);

    // R9: an illegal result carries no side effect.
    a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out.illegal) |-> !out.wb_en && !out.ind && !busy);
endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [3:0]  req_mode,
    input  logic        req_ind,
    input  logic [1:0]  req_sel,
    input  logic [15:0] req_off,
    input  logic [15:0] reg_x,
    input  logic [15:0] reg_y,
    input  logic [15:0] reg_u,
    input  logic [15:0] reg_s,
    input  logic [15:0] reg_pc,
    input  logic [7:0]  acc_a,
    input  logic [7:0]  acc_b,
    input  logic        page_we,
    input  logic [7:0]  page_wdata,
    input  logic        ptr_valid,
    input  logic [15:0] ptr_data,
    output logic        busy,
    output logic        res_valid,
    output logic [15:0] res_addr,
    output logic        res_ind,
    output logic        res_illegal,
    output logic        wb_en,
    output logic [1:0]  wb_sel,
    output logic [15:0] wb_value
);
    ea_mode_e   mode;
    ptr_sel_e   sel;
    addr_t      base;
    byte_t      page;
    ea_result_t calc, held;

    assign mode = ea_mode_e'(req_mode);
    assign sel  = ptr_sel_e'(req_sel);

    ea_base_select #(.AW(ADDR_W), .NPTR(4)) u_base (
        .sel   (sel),
        .ptr_x (reg_x),
        .ptr_y (reg_y),
        .ptr_u (reg_u),
        .ptr_s (reg_s),
        .base  (base)
    );

    ea_page_reg #(.DW(DATA_W)) u_page (
        .clk   (clk),
        .rst   (rst),
        .we    (page_we),
        .wdata (page_wdata),
        .page  (page)
    );

    ea_calc #(.AW(ADDR_W), .DW(DATA_W)) u_calc (
        .mode  (mode),
        .ind   (req_ind),
        .sel   (sel),
        .base  (base),
        .pc    (reg_pc),
        .off   (req_off),
        .acc_a (acc_a),
        .acc_b (acc_b),
        .page  (page),
        .res   (calc)
    );

    ea_seq #(.AW(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .calc      (calc),
        .ptr_valid (ptr_valid),
        .ptr_data  (ptr_data),
        .busy      (busy),
        .out_valid (res_valid),
        .out       (held)
    );

    assign res_addr    = held.addr;
    assign res_ind     = held.ind;
    assign res_illegal = held.illegal;
    assign wb_en       = held.wb_en;
    assign wb_sel      = held.wb_sel;
    assign wb_value    = held.wb_value;

    // R13: an accepted request answers in the next cycle.
    a_r13_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> res_valid);

    // R5: post-increment by 2 writes back pointer+2 and addresses the old value.
    a_r5_inc2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && req_mode == 4'd10) |=>
            wb_en && wb_value == $past(base) + 16'd2 && res_addr == $past(base));

    // R6: pre-decrement addresses the written-back value.
    a_r6_dec_match: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && (req_mode == 4'd11 || req_mode == 4'd12) && !req_ind) |=>
            wb_en && res_addr == wb_value);
endmodule

// File: tb/ea_unit_bench.sv
module ea_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_mode = '0;
    logic        req_ind = 1'b0;
    logic [1:0]  req_sel = '0;
    logic [15:0] req_off = '0;
    logic [15:0] reg_x = 16'h1000, reg_y = 16'h2000, reg_u = 16'h3000, reg_s = 16'h4000;
    logic [15:0] reg_pc = 16'h8000;
    logic [7:0]  acc_a = 8'h80, acc_b = 8'h10;
    logic        page_we = 1'b0;
    logic [7:0]  page_wdata = '0;
    logic        ptr_valid = 1'b0;
    logic [15:0] ptr_data = '0;
    logic        busy, res_valid, res_ind, res_illegal, wb_en;
    logic [15:0] res_addr, wb_value;
    logic [1:0]  wb_sel;

    always #10 clk = ~clk;  // 50 MHz

    ea_unit u_ea_unit (.*);

    typedef struct {
        logic [15:0] addr;
        bit          ind;
        bit          ill;
        bit          wb;
        logic [1:0]  sel;
        logic [15:0] wbv;
        int          due;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    int   cyc = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] m, input bit ind, input logic [1:0] s, input logic [15:0] off,
                        input logic [15:0] ea, input bit eind, input bit eill, input bit ewb,
                        input logic [15:0] ewbv, input string tag);
        exp_t e;
        e.addr = ea; e.ind = eind; e.ill = eill; e.wb = ewb; e.sel = s; e.wbv = ewbv;
        e.due = cyc + 1; e.tag = tag;
        q.push_back(e);
        req_mode = m; req_ind = ind; req_sel = s; req_off = off; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic give_ptr(input logic [15:0] d, input string tag);
        exp_t e;
        e.addr = d; e.ind = 1'b0; e.ill = 1'b0; e.wb = 1'b0; e.sel = 2'd0; e.wbv = '0;
        e.due = cyc + 1; e.tag = tag;
        q.push_back(e);
        ptr_data = d; ptr_valid = 1'b1;
        @(negedge clk);
        ptr_valid = 1'b0;
    endtask

    // Monitor: pops the scoreboard on every result.
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R12 unexpected result", {47'd0, res_valid, res_addr}, 64'd0);
            end else begin
                exp_t e;
                bit ok;
                e = q.pop_front();
                ok = (res_ind == e.ind) && (res_illegal == e.ill) && (wb_en == e.wb) && (cyc == e.due);
                if (!e.ill) ok = ok && (res_addr == e.addr);
                if (e.wb) ok = ok && (wb_sel == e.sel) && (wb_value == e.wbv);
                check(ok, {e.tag, " R13"},
                      {res_ind, res_illegal, wb_en, 13'd0, res_addr, 16'(cyc - e.due), wb_value},
                      {e.ind, e.ill, e.wb, 13'd0, e.addr, 16'd0, e.wbv});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 64'd0, 64'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(res_valid == 1'b0, "R1 res_valid", {63'd0, res_valid}, 64'd0);
        check(busy == 1'b0, "R1 busy", {63'd0, busy}, 64'd0);
        send(4'd0, 0, 0, 16'hFF34, 16'h0034, 0, 0, 0, 0, "R1 page reset");
        // R2 direct with new page, extended
        page_wdata = 8'h81; page_we = 1'b1;
        @(negedge clk);
        page_we = 1'b0;
        send(4'd0, 0, 0, 16'hAB12, 16'h8112, 0, 0, 0, 0, "R2 direct");
        send(4'd1, 0, 0, 16'hBEEF, 16'hBEEF, 0, 0, 0, 0, "R2 extended");
        // R3 constant offsets
        send(4'd2, 0, 1, 16'h5555, 16'h2000, 0, 0, 0, 0, "R3 zero");
        send(4'd3, 0, 0, 16'h0010, 16'h0FF0, 0, 0, 0, 0, "R3 off5 neg");
        send(4'd3, 0, 0, 16'hFFE5, 16'h1005, 0, 0, 0, 0, "R3 off5 pos");
        send(4'd4, 0, 2, 16'h0080, 16'h2F80, 0, 0, 0, 0, "R3 off8");
        send(4'd5, 0, 3, 16'h1234, 16'h5234, 0, 0, 0, 0, "R3 off16");
        // R4 accumulator offsets
        send(4'd6, 0, 0, 16'h0000, 16'h0F80, 0, 0, 0, 0, "R4 acc A");
        send(4'd7, 0, 1, 16'h0000, 16'h2010, 0, 0, 0, 0, "R4 acc B");
        send(4'd8, 0, 2, 16'h0000, 16'hB010, 0, 0, 0, 0, "R4 acc D");
        // R5 post-increment, R6 pre-decrement
        send(4'd9,  0, 0, 16'h0, 16'h1000, 0, 0, 1, 16'h1001, "R5 inc1");
        send(4'd10, 0, 3, 16'h0, 16'h4000, 0, 0, 1, 16'h4002, "R5 inc2");
        send(4'd11, 0, 1, 16'h0, 16'h1FFF, 0, 0, 1, 16'h1FFF, "R6 dec1");
        send(4'd12, 0, 2, 16'h0, 16'h2FFE, 0, 0, 1, 16'h2FFE, "R6 dec2");
        // R7 PC-relative
        send(4'd13, 0, 0, 16'h00F0, 16'h7FF0, 0, 0, 0, 0, "R7 pcrel8");
        send(4'd14, 0, 0, 16'h0100, 16'h8100, 0, 0, 0, 0, "R7 pcrel16");
        // R8 wrap
        send(4'd5, 0, 3, 16'hD000, 16'h1000, 0, 0, 0, 0, "R8 wrap add");
        reg_x = 16'h0000;
        send(4'd12, 0, 0, 16'h0, 16'hFFFE, 0, 0, 1, 16'hFFFE, "R8 wrap dec");
        reg_x = 16'hFFFF;
        send(4'd9, 0, 0, 16'h0, 16'hFFFF, 0, 0, 1, 16'h0000, "R8 wrap inc");
        reg_x = 16'h1000;
        // R9 illegal combinations
        send(4'd3, 1, 0, 16'h0001, 16'h0, 0, 1, 0, 0, "R9 off5 ind");
        send(4'd9, 1, 0, 16'h0, 16'h0, 0, 1, 0, 0, "R9 inc1 ind");
        send(4'd15, 0, 0, 16'h0, 16'h0, 0, 1, 0, 0, "R9 reserved");
        check(busy == 1'b0, "R9 not busy", {63'd0, busy}, 64'd0);
        // R10 indirect with 8-bit offset
        send(4'd4, 1, 0, 16'h0004, 16'h1004, 1, 0, 0, 0, "R10 ind first");
        check(busy == 1'b1, "R10 busy", {63'd0, busy}, 64'd1);
        @(negedge clk);
        give_ptr(16'hCAFE, "R10 ind final");
        check(busy == 1'b0, "R10 busy cleared", {63'd0, busy}, 64'd0);
        // R11 indirect post-increment writes back once; R12 request dropped while busy
        send(4'd10, 1, 1, 16'h0, 16'h2000, 1, 0, 1, 16'h2002, "R11 ind inc2 first");
        req_mode = 4'd1; req_ind = 1'b0; req_off = 16'h7777; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R12 still busy", {63'd0, busy}, 64'd1);
        give_ptr(16'h1234, "R11 ind final no wb");
        // R10 extended indirect back to back with a plain request
        send(4'd1, 1, 0, 16'hFFF0, 16'hFFF0, 1, 0, 0, 0, "R10 ext ind");
        give_ptr(16'h00AA, "R10 ext final");
        send(4'd2, 0, 3, 16'h0, 16'h4000, 0, 0, 0, 0, "R13 after ind");
        repeat (3) @(negedge clk);
        check(q.size() == 0, "R13 scoreboard drained", 64'(q.size()), 64'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule